// File: doc/BRIEF.md
# Dual 8-bit Compare Timer with 16-bit Chaining

This block holds two independent 8-bit up-counters. Each has two compare values (A and B), a clock-source selector with a prescaler of irregular divide ratios, and three interrupt pulses: compare A, compare B and wrap. A selectable clear source restarts the counter on a compare A or compare B match, so each counter can act as a programmable period generator.

Channel 0 can be switched into a chained mode. The two counters then act as one 16-bit counter, with channel 0 as the high byte and channel 1 as the low byte. The compare registers pair up in the same way, and channel 1's wrap carries into channel 0. The 16-bit counter steps at channel 1's rate and uses channel 0's control settings. Its events appear on the channel 0 outputs.

Software reaches the registers through a simple byte/halfword bus. Even addresses select channel 0 and odd addresses select channel 1. Halfword accesses to the compare, counter and clock registers move both channels at once. Reads are combinational and writes take effect at the next clock edge.

Top module: `tmr8_pair`

## Requirements
- R1: After reset, control and clock registers read 0x00, compare A and B read 0xFF, counters read 0x00, and all six interrupt outputs are low.
- R2: A channel counts only when its clock register bits 4:3 equal 1. Bits 2:0 then pick the divide ratio: 0 stopped, 1 /1, 2 /2, 3 /8, 4 /32, 5 /64, 6 /1024, 7 /8192. Any other source code holds the counter.
- R3: On a count step taken while the counter equals compare A (or compare B), a one-cycle pulse appears on that channel's compare A (or B) output, if control bit 6 (or bit 7) is set. When both compares match on the same step, both outputs pulse.
- R4: Control bits 4:3 pick the clear source: 1 clears on compare A match and 2 clears on compare B match. A clear loads 0 instead of incrementing, giving a period of compare+1 steps. Codes 0 and 3 never clear.
- R5: A count step taken at 0xFF lands on 0x00 and pulses the wrap output if control bit 5 is set.
- R6: When channel 0 clock bits 4:3 equal 3, {counter0,counter1} forms a 16-bit counter with compares {A0,A1} and {B0,B1}. It steps at channel 1's rate and follows channel 0's control bits. It wraps from 0xFFFF and reports its events on the index-0 outputs, while the index-1 outputs stay low.
- R7: Address bits 3:1 select the register: 0 control, 1 status, 2 compare A, 3 compare B, 4 counter, 5 clock. Bit 0 selects the channel. A byte read returns the value in bits 7:0 with bits 15:8 zero. Unimplemented bits read 0: control keeps bits 7:3, status keeps bits 5:0, and clock keeps bits 7 and 4:0.
- R8: A halfword access at an even address of compare A, compare B, counter or clock reads and writes channel 0 in bits 15:8 and channel 1 in bits 7:0.
- R9: The following accesses read 0xFFFF and are ignored on write: a halfword at an odd address, a halfword to control or status, or any access with address bits 3:1 equal to 6 or 7.
- R10: Channel 1 status bit 4 always reads 1, and channel 0 status resets to 0x00.
- R11: A bus write to a counter byte takes that cycle in place of the count step, and no compare or wrap event fires from the dropped step. In chained mode, a write to either byte drops the 16-bit step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_hw | input | 1 | 1 halfword, 0 byte |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| cma_irq | output | 2 | Compare A pulse per channel |
| cmb_irq | output | 2 | Compare B pulse per channel |
| ovf_irq | output | 2 | Wrap pulse per channel |

## Verification
Assertions check several properties on every cycle:
- the index-1 outputs stay silent in chained mode;
- a wrap pulse only follows an enabled wrap and leaves the counter at zero;
- a stopped channel 1 counter never moves unless written;
- a rejected halfword leaves the control and status bytes untouched;
- a counter write always wins over the step.

The divide ratios, clear periods, simultaneous A/B matches, 16-bit carry and clear, halfword merging and reset values can only be shown by the bench's scenarios. Those scenarios run the counter for a known number of steps and read the result back.

// File: rtl/tmr8_pair.sv
module tmr8_pair (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic        bus_hw,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic [1:0]  cma_irq,
  output logic [1:0]  cmb_irq,
  output logic [1:0]  ovf_irq
);
  localparam int         PW       = 13;
  localparam logic [2:0] RG_CTL   = 3'd0;
  localparam logic [2:0] RG_STA   = 3'd1;
  localparam logic [2:0] RG_CPA   = 3'd2;
  localparam logic [2:0] RG_CPB   = 3'd3;
  localparam logic [2:0] RG_CNT   = 3'd4;
  localparam logic [2:0] RG_CKC   = 3'd5;
  localparam logic [1:0] SRC_INT  = 2'd1;
  localparam logic [1:0] SRC_CASC = 2'd3;
  localparam logic [1:0] CLR_A    = 2'd1;
  localparam logic [1:0] CLR_B    = 2'd2;

  logic [7:0]    ctl [2];
  logic [7:0]    sta [2];
  logic [7:0]    cpa [2];
  logic [7:0]    cpb [2];
  logic [7:0]    cnt [2];
  logic [7:0]    ckc [2];
  logic [PW-1:0] pre;

  wire [2:0] ridx  = bus_addr[3:1];
  wire       bad   = (ridx > RG_CKC) || (bus_hw && (bus_addr[0] || ridx < RG_CPA));
  wire       wr_ok = bus_en && bus_we && !bad;
  wire [1:0] wch   = !wr_ok ? 2'b00 : bus_hw ? 2'b11 : (bus_addr[0] ? 2'b10 : 2'b01);
  wire [1:0] wcnt  = (ridx == RG_CNT) ? wch : 2'b00;
  wire [7:0] wb0   = bus_hw ? bus_wdata[15:8] : bus_wdata[7:0];
  wire [7:0] wb1   = bus_wdata[7:0];
  wire       casc  = ckc[0][4:3] == SRC_CASC;

  function automatic logic tick_of(input logic [2:0] cks, input logic [PW-1:0] p);
    case (cks)
      3'd0:    tick_of = 1'b0;
      3'd1:    tick_of = 1'b1;
      3'd2:    tick_of = p[0];
      3'd3:    tick_of = &p[2:0];
      3'd4:    tick_of = &p[4:0];
      3'd5:    tick_of = &p[5:0];
      3'd6:    tick_of = &p[9:0];
      default: tick_of = &p[12:0];
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;

  logic [1:0] run, stp, hit_a, hit_b, top;
  logic [7:0] nxt [2];

  wire [15:0] c16   = {cnt[0], cnt[1]};
  wire        h16a  = c16 == {cpa[0], cpa[1]};
  wire        h16b  = c16 == {cpb[0], cpb[1]};
  wire        top16 = &c16;
  wire        clr16 = (ctl[0][4:3] == CLR_A && h16a) || (ctl[0][4:3] == CLR_B && h16b);
  wire [15:0] n16   = clr16 ? 16'h0000 : c16 + 16'd1;
  wire        stp16 = run[1] && (wcnt == 2'b00);

  for (genvar c = 0; c < 2; c++) begin : g_ch
    wire [7:0] wb      = (c == 0) ? wb0 : wb1;
    wire [7:0] sta_rst = (c == 0) ? 8'h00 : 8'h10;
    wire       clr_c;

    assign run[c]   = (ckc[c][4:3] == SRC_INT) && tick_of(ckc[c][2:0], pre);
    assign stp[c]   = run[c] && !wcnt[c];
    assign hit_a[c] = cnt[c] == cpa[c];
    assign hit_b[c] = cnt[c] == cpb[c];
    assign top[c]   = &cnt[c];
    assign clr_c    = (ctl[c][4:3] == CLR_A && hit_a[c]) || (ctl[c][4:3] == CLR_B && hit_b[c]);
    assign nxt[c]   = clr_c ? 8'h00 : cnt[c] + 8'd1;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ctl[c] <= 8'h00;
        sta[c] <= sta_rst;
        cpa[c] <= 8'hFF;
        cpb[c] <= 8'hFF;
        ckc[c] <= 8'h00;
      end else if (wch[c]) begin
        case (ridx)
          RG_CTL:  ctl[c] <= wb & 8'hF8;
          RG_STA:  sta[c] <= (wb & 8'h3F) | sta_rst;
          RG_CPA:  cpa[c] <= wb;
          RG_CPB:  cpb[c] <= wb;
          RG_CKC:  ckc[c] <= wb & 8'h9F;
          default: ;
        endcase
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      cnt[c] <= 8'h00;
      else if (wcnt[c]) cnt[c] <= wb;
      else if (casc) begin
        if (stp16) cnt[c] <= (c == 0) ? n16[15:8] : n16[7:0];
      end else if (stp[c]) cnt[c] <= nxt[c];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cma_irq <= 2'b00;
      cmb_irq <= 2'b00;
      ovf_irq <= 2'b00;
    end else begin
      cma_irq[0] <= casc ? (stp16 && h16a && ctl[0][6])  : (stp[0] && hit_a[0] && ctl[0][6]);
      cmb_irq[0] <= casc ? (stp16 && h16b && ctl[0][7])  : (stp[0] && hit_b[0] && ctl[0][7]);
      ovf_irq[0] <= casc ? (stp16 && top16 && ctl[0][5]) : (stp[0] && top[0] && ctl[0][5]);
      cma_irq[1] <= !casc && stp[1] && hit_a[1] && ctl[1][6];
      cmb_irq[1] <= !casc && stp[1] && hit_b[1] && ctl[1][7];
      ovf_irq[1] <= !casc && stp[1] && top[1] && ctl[1][5];
    end

  function automatic logic [7:0] rbyte(input int c, input logic [2:0] i);
    case (i)
      RG_CTL:  rbyte = ctl[c];
      RG_STA:  rbyte = sta[c];
      RG_CPA:  rbyte = cpa[c];
      RG_CPB:  rbyte = cpb[c];
      RG_CNT:  rbyte = cnt[c];
      RG_CKC:  rbyte = ckc[c];
      default: rbyte = 8'hFF;
    endcase
  endfunction

  always_comb
    if (bad)         bus_rdata = 16'hFFFF;
    else if (bus_hw) bus_rdata = {rbyte(0, ridx), rbyte(1, ridx)};
    else             bus_rdata = {8'h00, rbyte(int'(bus_addr[0]), ridx)};

  assert_casc_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    casc |=> (cma_irq[1] == 1'b0 && cmb_irq[1] == 1'b0 && ovf_irq[1] == 1'b0));

  assert_wrap_zero0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq[0] |-> cnt[0] == 8'h00);

  assert_wrap_zero1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq[1] |-> cnt[1] == 8'h00);

  assert_wrap_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq[0] |-> $past(ctl[0][5]));

  assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ckc[1][4:3] != SRC_INT || ckc[1][2:0] == 3'd0) && !wcnt[1]) |=> cnt[1] == $past(cnt[1]));

  assert_reject_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_hw && ridx < RG_CPA) |=>
      (ctl[0] == $past(ctl[0]) && ctl[1] == $past(ctl[1]) && sta[0] == $past(sta[0]) && sta[1] == $past(sta[1])));

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt[1] |=> cnt[1] == $past(wb1));
endmodule

// File: tb/tmr8_pair_tb_top.sv
module tmr8_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0, bus_hw = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic [1:0]  cma_irq, cmb_irq, ovf_irq;

  always #2 clk = ~clk;

  tmr8_pair dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_hw(bus_hw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cma_irq(cma_irq), .cmb_irq(cmb_irq), .ovf_irq(ovf_irq)
  );

  int n_chk = 0, n_fail = 0;
  int n_cma [2], n_cmb [2], n_ovf [2];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin n_cma[c] = 0; n_cmb[c] = 0; n_ovf[c] = 0; end
    forever begin
      @(negedge clk);
      #1;
      if (bus_en && !bus_we && exp_q.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, int'(bus_rdata), int'(e));
      end
      for (int c = 0; c < 2; c++) begin
        n_cma[c] += int'(cma_irq[c]);
        n_cmb[c] += int'(cmb_irq[c]);
        n_ovf[c] += int'(ovf_irq[c]);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic hw, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_hw = hw; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [3:0] a, input logic hw, input logic [15:0] e, input string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_hw = hw; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
    end
  endtask

  task automatic clr_irq;
    for (int c = 0; c < 2; c++) begin n_cma[c] = 0; n_cmb[c] = 0; n_ovf[c] = 0; end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    chk("R1 irq idle", int'({cma_irq, cmb_irq, ovf_irq}), 0);
    rd(4'h0, 1'b0, 16'h0000, "R1 ctl0");
    rd(4'h2, 1'b0, 16'h0000, "R10 sta0");
    rd(4'h3, 1'b0, 16'h0010, "R10 sta1");
    rd(4'h4, 1'b1, 16'hFFFF, "R1 cmpA pair");
    rd(4'h7, 1'b0, 16'h00FF, "R1 cmpB1");
    rd(4'h8, 1'b1, 16'h0000, "R1 counters");
    rd(4'hA, 1'b1, 16'h0000, "R1 clocks");

    wr(4'h0, 1'b0, 16'h00FF); rd(4'h0, 1'b0, 16'h00F8, "R7 ctl mask");
    wr(4'hB, 1'b0, 16'h00FF); rd(4'hB, 1'b0, 16'h009F, "R7 ckc mask");
    wr(4'hB, 1'b0, 16'h0000);
    wr(4'h2, 1'b0, 16'h00FF); rd(4'h2, 1'b0, 16'h003F, "R7 sta mask");
    wr(4'h3, 1'b0, 16'h0000); rd(4'h3, 1'b0, 16'h0010, "R10 sta1 bit4");

    wr(4'h0, 1'b1, 16'h0000); rd(4'h0, 1'b0, 16'h00F8, "R9 hw ctl write ignored");
    rd(4'h0, 1'b1, 16'hFFFF, "R9 hw ctl read");
    rd(4'h9, 1'b1, 16'hFFFF, "R9 hw odd read");
    rd(4'hC, 1'b0, 16'hFFFF, "R9 unmapped read");
    wr(4'h5, 1'b1, 16'h1234); rd(4'h5, 1'b0, 16'h00FF, "R9 hw odd write ignored");
    wr(4'h0, 1'b0, 16'h0000);

    wr(4'h4, 1'b1, 16'h1234);
    rd(4'h4, 1'b0, 16'h0012, "R8 upper to ch0");
    rd(4'h5, 1'b0, 16'h0034, "R8 lower to ch1");
    rd(4'h4, 1'b1, 16'h1234, "R8 hw read");

    // clear on A, period 6, 20 steps
    wr(4'h0, 1'b0, 16'h0048); wr(4'h4, 1'b0, 16'h0005); wr(4'h8, 1'b0, 16'h0000);
    idle(1); clr_irq();
    wr(4'hA, 1'b0, 16'h0009); idle(19); wr(4'hA, 1'b0, 16'h0000); idle(2);
    rd(4'h8, 1'b0, 16'h0002, "R4 clear on A count");
    idle(1);
    chk("R3 cmpA pulses", n_cma[0], 3);

    // A and B on the same value, no clear, 10 steps
    wr(4'h0, 1'b0, 16'h00C0); wr(4'h4, 1'b0, 16'h0003); wr(4'h6, 1'b0, 16'h0003);
    wr(4'h8, 1'b0, 16'h0000); idle(1); clr_irq();
    wr(4'hA, 1'b0, 16'h0009); idle(9); wr(4'hA, 1'b0, 16'h0000); idle(2);
    rd(4'h8, 1'b0, 16'h000A, "R4 no clear count");
    idle(1);
    chk("R3 both A", n_cma[0], 1);
    chk("R3 both B", n_cmb[0], 1);

    // clear on B, period 3, 7 steps
    wr(4'h0, 1'b0, 16'h0010); wr(4'h6, 1'b0, 16'h0002); wr(4'h4, 1'b0, 16'h0000);
    wr(4'h8, 1'b0, 16'h0000);
    wr(4'hA, 1'b0, 16'h0009); idle(6); wr(4'hA, 1'b0, 16'h0000); idle(2);
    rd(4'h8, 1'b0, 16'h0001, "R4 clear on B count");

    // ch1 wrap
    wr(4'h1, 1'b0, 16'h0020); wr(4'h5, 1'b0, 16'h00FF); wr(4'h9, 1'b0, 16'h00FA);
    idle(1); clr_irq();
    wr(4'hB, 1'b0, 16'h0009); idle(9); wr(4'hB, 1'b0, 16'h0000); idle(2);
    rd(4'h9, 1'b0, 16'h0004, "R5 wrap count");
    idle(1);
    chk("R5 wrap pulse ch1", n_ovf[1], 1);
    chk("R5 no wrap ch0", n_ovf[0], 0);

    // prescaler ratios on ch1
    wr(4'h1, 1'b0, 16'h0000);
    wr(4'h9, 1'b0, 16'h0000); wr(4'hB, 1'b0, 16'h000B); idle(79); wr(4'hB, 1'b0, 16'h0000); idle(1);
    rd(4'h9, 1'b0, 16'h000A, "R2 divide by 8");
    wr(4'h9, 1'b0, 16'h0000); wr(4'hB, 1'b0, 16'h000A); idle(39); wr(4'hB, 1'b0, 16'h0000); idle(1);
    rd(4'h9, 1'b0, 16'h0014, "R2 divide by 2");
    wr(4'h9, 1'b0, 16'h0000); wr(4'hB, 1'b0, 16'h000C); idle(319); wr(4'hB, 1'b0, 16'h0000); idle(1);
    rd(4'h9, 1'b0, 16'h000A, "R2 divide by 32");
    wr(4'h9, 1'b0, 16'h0033); wr(4'hB, 1'b0, 16'h0008); idle(19); wr(4'hB, 1'b0, 16'h0000); idle(1);
    rd(4'h9, 1'b0, 16'h0033, "R2 ratio code 0 stopped");
    wr(4'hB, 1'b0, 16'h0001); idle(19); wr(4'hB, 1'b0, 16'h0000); idle(1);
    rd(4'h9, 1'b0, 16'h0033, "R2 source 0 holds");

    // counter write beats the step
    wr(4'h1, 1'b0, 16'h0020); idle(1); clr_irq();
    wr(4'hB, 1'b0, 16'h0009);
    repeat (5) wr(4'h9, 1'b0, 16'h00FF);
    wr(4'hB, 1'b0, 16'h0000); idle(2);
    rd(4'h9, 1'b0, 16'h0000, "R11 count after writes");
    idle(1);
    chk("R11 one wrap only", n_ovf[1], 1);

    // chained 16-bit, clear on A at 0x0102, 300 steps
    wr(4'h0, 1'b0, 16'h0068); wr(4'h1, 1'b0, 16'h00E0);
    wr(4'h4, 1'b1, 16'h0102); wr(4'h6, 1'b1, 16'hFFFF); wr(4'h8, 1'b1, 16'h0000);
    idle(1); clr_irq();
    wr(4'hA, 1'b1, 16'h1809); idle(299); wr(4'hA, 1'b1, 16'h1800); idle(2);
    rd(4'h8, 1'b1, 16'h0029, "R6 chained clear count");
    idle(1);
    chk("R6 chained cmpA on ch0", n_cma[0], 1);
    chk("R6 ch1 cmpA quiet", n_cma[1], 0);
    chk("R6 ch1 cmpB quiet", n_cmb[1], 0);
    chk("R6 ch1 wrap quiet", n_ovf[1], 0);

    // chained wrap through 0xFFFF
    wr(4'h0, 1'b0, 16'h0020); wr(4'h8, 1'b1, 16'hFFFE); idle(1); clr_irq();
    wr(4'hA, 1'b1, 16'h1809); idle(4); wr(4'hA, 1'b1, 16'h1800); idle(2);
    rd(4'h8, 1'b1, 16'h0003, "R6 chained wrap count");
    idle(1);
    chk("R6 chained wrap on ch0", n_ovf[0], 1);
    chk("R6 chained wrap ch1 quiet", n_ovf[1], 0);

    idle(3);
    chk("R1 read queue drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule